// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timing Generator

This block produces the serial clock and the active-low chip select for the master side of an SPI link. Its timebase is a half-period down-counter that reloads from an 8-bit divider, so each SCLK level lasts `div+1` source clocks and SCLK runs at the source frequency divided by `2*(div+1)`. The clock polarity and phase inputs set the resting level of SCLK and decide which edge carries the launch strobe and which edge carries the sample strobe. The shift logic uses these one-cycle strobes.

A phase sequencer starts a frame by holding `start_req` high. The block answers with a one-cycle `start_ack` as chip select falls. The sequencer raises `stop_req` during the last bit. At every full SCLK period the block checks `stop_req` and ends the frame there. Three delays are programmed in half SCLK periods. The first is setup, from chip select falling to the first SCLK edge. The second is hold, from the last SCLK edge to chip select rising, and it uses the same count as setup. The third is the minimum chip-select-high gap before the next frame. A start request that arrives during the gap waits until the gap has ended. A synchronous soft reset returns the block to idle at once.

Top module: `spi_sclk_cs_timer`

## Requirements
- R1: While a frame runs, SCLK changes level every `div+1` source clocks.
- R2: After reset and whenever idle, `cs_n` is 1, `busy` is 0 and `sclk` equals `cpol`.
- R3: With `cpha`=0, `sample` pulses on every odd-numbered SCLK edge (SCLK moving away from `cpol`). `launch` pulses together with `start_ack` and on every even-numbered edge except the last of the frame, so the frame has one launch per bit.
- R4: With `cpha`=1, `launch` pulses on every odd-numbered SCLK edge and `sample` pulses on every even-numbered edge (SCLK returning to `cpol`). `launch` and `sample` are never high together.
- R5: The first SCLK edge comes exactly `(cs_setup+1)*(div+1)` source clocks after `cs_n` falls.
- R6: `cs_n` rises exactly `(cs_setup+1)*(div+1)` source clocks after the last SCLK edge, and `sclk` equals `cpol` at that moment.
- R7: `busy` stays high for exactly `(cs_gap+1)*(div+1)` source clocks after `cs_n` rises. A `start_req` held through this interval makes `cs_n` fall again exactly one clock after `busy` drops.
- R8: `stop_req` is checked on each even-numbered SCLK edge. When it is high there, that edge is the last one, so a frame of N bits has exactly 2N SCLK edges.
- R9: `start_ack` is a one-cycle pulse in the same cycle in which `cs_n` falls and `busy` rises.
- R10: `soft_rst` high at a clock edge returns the block to idle by the next cycle: `cs_n`=1, `busy`=0, `sclk`=`cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous active-high return to idle |
| div | input | 8 | Half-period length minus one, in source clocks |
| cpol | input | 1 | SCLK resting level |
| cpha | input | 1 | 0: sample on odd edges, 1: sample on even edges |
| cs_setup | input | 2 | Setup/hold delay minus one, in half SCLK periods |
| cs_gap | input | 4 | Minimum CS-high time minus one, in half SCLK periods |
| start_req | input | 1 | Request to open a frame, held until acknowledged |
| stop_req | input | 1 | End the frame at the next even-numbered edge |
| start_ack | output | 1 | Frame accepted, one cycle |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| launch | output | 1 | Shift-out strobe, one cycle |
| sample | output | 1 | Capture strobe, one cycle |
| busy | output | 1 | Frame or CS-high gap in progress |

## Verification
The assertions check on every cycle that SCLK moves only while chip select is low, that a sample strobe always falls on an SCLK edge, that launch and sample never coincide, that chip select rises only with SCLK at rest, that the acknowledge comes with chip select falling, and that soft reset reaches idle. The exact clock counts cannot be seen cycle by cycle. These are the half-period length, the setup, hold and gap durations, the edge count set by `stop_req`, and how a start held through the gap is treated. The bench measures them across a table of divider, mode and delay settings.

// File: rtl/spi_sclk_cs_timer.sv
module spi_sclk_cs_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic [7:0] div,
  input  logic       cpol,
  input  logic       cpha,
  input  logic [1:0] cs_setup,
  input  logic [3:0] cs_gap,
  input  logic       start_req,
  input  logic       stop_req,
  output logic       start_ack,
  output logic       sclk,
  output logic       cs_n,
  output logic       launch,
  output logic       sample,
  output logic       busy
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RUN, S_HOLD, S_GAP} state_t;

  state_t     state;
  logic [7:0] hcnt;
  logic [3:0] dcnt;
  logic       tog;
  logic       tick;

  assign tick = (state != S_IDLE) && (hcnt == 8'd0);
  assign sclk = cpol ^ tog;
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; hcnt <= '0; dcnt <= '0; tog <= 1'b0;
      cs_n <= 1'b1; start_ack <= 1'b0; launch <= 1'b0; sample <= 1'b0;
    end else if (soft_rst) begin
      state <= S_IDLE; hcnt <= '0; dcnt <= '0; tog <= 1'b0;
      cs_n <= 1'b1; start_ack <= 1'b0; launch <= 1'b0; sample <= 1'b0;
    end else begin
      start_ack <= 1'b0;
      launch    <= 1'b0;
      sample    <= 1'b0;
      if (state != S_IDLE) hcnt <= tick ? div : hcnt - 8'd1;
      case (state)
        S_IDLE: if (start_req) begin
          state     <= S_SETUP;
          cs_n      <= 1'b0;
          hcnt      <= div;
          dcnt      <= {2'b00, cs_setup};
          start_ack <= 1'b1;
          launch    <= !cpha;
        end
        S_SETUP: if (tick) begin
          if (dcnt == 4'd0) begin
            state <= S_RUN;
            tog   <= 1'b1;
            if (cpha) launch <= 1'b1; else sample <= 1'b1;
          end else dcnt <= dcnt - 4'd1;
        end
        S_RUN: if (tick) begin
          if (tog) begin
            tog <= 1'b0;
            if (cpha) sample <= 1'b1;
            if (stop_req) begin
              state <= S_HOLD;
              dcnt  <= {2'b00, cs_setup};
            end else if (!cpha) launch <= 1'b1;
          end else begin
            tog <= 1'b1;
            if (cpha) launch <= 1'b1; else sample <= 1'b1;
          end
        end
        S_HOLD: if (tick) begin
          if (dcnt == 4'd0) begin
            state <= S_GAP;
            cs_n  <= 1'b1;
            dcnt  <= cs_gap;
          end else dcnt <= dcnt - 4'd1;
        end
        S_GAP: if (tick) begin
          if (dcnt == 4'd0) state <= S_IDLE;
          else dcnt <= dcnt - 4'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SCLK_ONLY_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk) && $stable(cpol)) |-> (!cs_n || $past(soft_rst))); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && sample)); // R4
  AST_SAMPLE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && $stable(cpol)) |-> !$stable(sclk)); // R3
  AST_CS_RISE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (sclk == cpol)); // R6
  AST_ACK_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ack |-> ($fell(cs_n) && busy)); // R9
  AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cs_n && !busy && !tog)); // R10

endmodule

// File: tb/spi_sclk_cs_timer_tb_top.sv
`timescale 1ns/1ps
module spi_sclk_cs_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic [7:0] div = 8'd0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic [1:0] cs_setup = 2'd0;
  logic [3:0] cs_gap = 4'd0;
  logic       start_req = 1'b0;
  logic       stop_req = 1'b0;
  logic       start_ack, sclk, cs_n, launch, sample, busy;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  spi_sclk_cs_timer dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .div(div), .cpol(cpol),
    .cpha(cpha), .cs_setup(cs_setup), .cs_gap(cs_gap), .start_req(start_req),
    .stop_req(stop_req), .start_ack(start_ack), .sclk(sclk), .cs_n(cs_n),
    .launch(launch), .sample(sample), .busy(busy)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // div[23:16] cpol[15] cpha[14] cs_setup[13:12] cs_gap[11:8] nbits[7:0]
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'd0, 1'b0, 1'b0, 2'd0, 4'd0,  8'd1},
    {8'd1, 1'b0, 1'b1, 2'd1, 4'd2,  8'd3},
    {8'd2, 1'b1, 1'b0, 2'd3, 4'd15, 8'd2},
    {8'd3, 1'b1, 1'b1, 2'd2, 4'd1,  8'd4},
    {8'd0, 1'b1, 1'b1, 2'd3, 4'd4,  8'd8},
    {8'd4, 1'b0, 1'b0, 2'd1, 4'd0,  8'd2}
  };

  task automatic run_xfer(input logic [23:0] v);
    int hp, nb, t, edges, samples, launches, last_e, fall_t, rise_t;
    logic prev_s, prev_c;
    @(negedge clk);
    div = v[23:16]; cpol = v[15]; cpha = v[14]; cs_setup = v[13:12]; cs_gap = v[11:8];
    nb = v[7:0]; hp = int'(v[23:16]) + 1;
    #1;
    chk(sclk == cpol && cs_n && !busy, "R2 idle level", sclk, cpol);
    start_req = 1'b1;
    t = 0; edges = 0; samples = 0; launches = 0; last_e = 0; fall_t = 0; rise_t = -1;
    prev_s = sclk; prev_c = cs_n;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); t++;
      if (start_ack) begin
        start_req = 1'b0; fall_t = t;
        chk(!cs_n && busy && prev_c, "R9 ack with cs fall", cs_n, 0);
      end
      if (sample) begin
        samples++;
        chk(sclk == (cpha ? cpol : !cpol) && sclk != prev_s,
            cpha ? "R4 sample on even edge" : "R3 sample on odd edge", sclk, cpha ? cpol : !cpol);
      end
      if (launch) begin
        launches++;
        chk(!sample, "R4 strobes exclusive", 1, 0);
      end
      if (sclk != prev_s) begin
        edges++;
        if (edges == 1) chk(t - fall_t == (int'(cs_setup) + 1) * hp, "R5 setup", t - fall_t, (int'(cs_setup) + 1) * hp);
        else chk(t - last_e == hp, "R1 half period", t - last_e, hp);
        if (launch) chk(cpha ? (edges % 2 == 1) : (edges % 2 == 0), "R3 R4 launch edge", edges, 0);
        last_e = t;
        if (edges == 2 * nb - 1) stop_req = 1'b1;
      end
      if (!prev_c && cs_n) begin
        stop_req = 1'b0; rise_t = t;
        chk(t - last_e == (int'(cs_setup) + 1) * hp, "R6 hold", t - last_e, (int'(cs_setup) + 1) * hp);
        chk(sclk == cpol, "R6 rest level", sclk, cpol);
        chk(edges == 2 * nb, "R8 edge count", edges, 2 * nb);
      end
      if (rise_t >= 0 && !busy) begin
        chk(t - rise_t == (int'(cs_gap) + 1) * hp, "R7 gap", t - rise_t, (int'(cs_gap) + 1) * hp);
        break;
      end
      prev_s = sclk; prev_c = cs_n;
    end
    chk(samples == nb, "R3 R4 sample count", samples, nb);
    chk(launches == nb, "R3 R4 launch count", launches, nb);
    chk(rise_t >= 0 && !busy, "R9 frame completes", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !busy && sclk == cpol && !start_ack, "R2 reset state", cs_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !busy && !launch && !sample, "R2 after reset", busy, 0);

    for (int i = 0; i < NV; i++) run_xfer(VEC[i]);

    // R7: start held through the gap
    begin
      int rise_t, t;
      @(negedge clk);
      div = 8'd1; cpol = 1'b0; cpha = 1'b0; cs_setup = 2'd0; cs_gap = 4'd3;
      start_req = 1'b1; stop_req = 1'b1;
      t = 0; rise_t = -1;
      for (int k = 0; k < 2000; k++) begin
        logic pc;
        pc = cs_n;
        @(negedge clk); t++;
        if (!pc && cs_n && rise_t < 0) rise_t = t;
        if (rise_t >= 0 && t > rise_t && !cs_n) break;
      end
      chk(rise_t >= 0 && t - rise_t == 4 * 2 + 1, "R7 held start waits gap", t - rise_t, 9);
      chk(start_ack, "R9 ack for held start", start_ack, 1);
      start_req = 1'b0;
      stop_req = 1'b0;
    end

    // R10: soft reset mid-frame, with cpol=1
    begin
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      cpol = 1'b1; cpha = 1'b1; div = 8'd2; cs_setup = 2'd0; cs_gap = 4'd0;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (7) @(negedge clk);
      chk(!cs_n && busy, "R10 frame running", cs_n, 0);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      chk(cs_n && !busy && sclk == cpol, "R10 soft reset idle", {cs_n, busy, sclk}, {1'b1, 1'b0, 1'b1});
      repeat (5) @(negedge clk);
      chk(cs_n && !busy && sclk == cpol && !launch && !sample, "R2 stays idle", busy, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule